// File: doc/BRIEF.md
# Folded-Column Range Shift Sequencer

This block moves a contiguous run of words in a word-addressed store by one position, in either direction, in a fixed small number of cycles that does not depend on how long the run is. The store is organised as `NCOL` columns of `CLEN` words each. The columns are chained end to end in a serpentine fold, so logical address `a` lives in column `a / CLEN` at row `a % CLEN`. Because of the fold, neighbouring columns move in opposite physical directions during a shift. At every column end, a word leaves one column and enters the next.

A command carries an insert address, a delete address and a data word.
- The word at the delete address is discarded.
- Every word between the two addresses moves one place toward the delete address.
- The new word is written at the insert address.

A long shift is broken into three ordered steps:
1. A partial shift of the column that holds the delete address.
2. A simultaneous shift of every column that lies strictly between the two endpoint columns.
3. A partial shift of the column that holds the insert address, combined with the write.

Before any step runs, each column's boundary word is copied into that column's carry register. This means no word can be overwritten before it has moved. When both addresses fall in the same column, the first two steps are not issued. A command with equal addresses is a plain single-word write.

The column array is modelled behaviourally. The step enables and the physical direction of each column are brought out as ports, and a combinational read port exposes the contents.

Top module: `sms_shift_top`

## Requirements
- R1: After reset the following hold:
  - `cmd_ready` is 1.
  - `done`, `wr_en`, `col_en`, `col_dir` and `row_en` are all 0.
  - Every word reads as 0.
- R2: When insert < delete, once `done` has pulsed:
  - Word `a` holds the old word `a-1` for every `a` with insert < a <= delete.
  - Word insert holds `cmd_data`.
  - All other words are unchanged.
- R3: When insert > delete, once `done` has pulsed:
  - Word `a` holds the old word `a+1` for every `a` with delete <= a < insert.
  - Word insert holds `cmd_data`.
  - All other words are unchanged.
- R4: When insert == delete, only that word changes, and it becomes `cmd_data`. The command takes a single step.
- R5: Address `a` maps to column `a / CLEN` and row `a % CLEN`. Words that cross one or more column ends during a shift arrive intact.
- R6: When the endpoint columns differ, the first step cycle does the following:
  - It enables only the delete column: `col_en` bit = delete column.
  - It enables rows 0..delete-row when insert < delete.
  - It enables rows delete-row..`CLEN-1` when insert > delete.
  - `wr_en` is 0.
- R7: A middle step is issued only when the endpoint columns are more than one apart. It enables every column strictly between them, enables all `CLEN` rows, and keeps `wr_en` at 0.
- R8: The last step does the following:
  - It enables only the insert column and sets `wr_en` to 1.
  - If both endpoints share a column, rows span from the lower row to the higher row.
  - Otherwise, rows span insert-row..`CLEN-1` when insert < delete, or 0..insert-row when insert > delete.
- R9: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. The steps then follow on consecutive cycles, and the number of steps is:
  - 1 when both endpoints share a column.
  - 2 when the endpoint columns are adjacent.
  - 3 otherwise.

  `cmd_ready` is 0 while steps run. `done` is 1 for exactly the cycle after the last step.
- R10: For each enabled column `c`, `col_dir[c]` = (insert <= delete) XOR (`c` odd). For a disabled column, `col_dir[c]` is 0.
- R11: While `cmd_ready` is 0, `cmd_valid` and the command fields are ignored. Neither the step sequence nor the stored words are affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, able to take a command |
| cmd_ins | input | AW | Insert address |
| cmd_del | input | AW | Delete address |
| cmd_data | input | W | Word written at the insert address |
| done | output | 1 | One-cycle pulse after the final step |
| col_en | output | NCOL | Columns shifting in the current step |
| col_dir | output | NCOL | Physical direction of each enabled column |
| row_en | output | CLEN | Rows shifting in the current step (shared by the enabled columns) |
| wr_en | output | 1 | Insert write in the current step |
| rd_addr | input | AW | Read address |
| rd_data | output | W | Word at `rd_addr`, combinational |

## Verification
A command accepted at edge E0 presents its first step in the cycle after E0. Each further step follows one cycle later, and the storage updates at the edge that closes each step. `done` therefore rises one cycle after the final step, which is 2, 3 or 4 cycles after E0.

The bench drives inputs on falling edges. At every falling edge of a command it compares the enables, directions, `cmd_ready` and `done` against a step list it has computed for that cycle. Only after `done` has been seen does it read every word back and compare it with a behavioural array model.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEL  = 2'd1,
    ST_MID  = 2'd2,
    ST_INS  = 2'd3
  } sms_step_e;
endpackage

// File: rtl/sms_seq.sv
module sms_seq
  import sms_pkg::*;
#(
  parameter int NCOL = 4,
  parameter int CLEN = 8,
  parameter int AW   = 5,
  parameter int CW   = (NCOL > 1) ? $clog2(NCOL) : 1,
  parameter int RW   = (CLEN > 1) ? $clog2(CLEN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [AW-1:0]   cmd_ins,
  input  logic [AW-1:0]   cmd_del,
  output logic            cmd_ready,
  output logic            accept,
  output logic            accept_up,
  output logic            up,
  output logic [NCOL-1:0] col_en,
  output logic [CLEN-1:0] row_en,
  output logic            wr_en,
  output logic [RW-1:0]   wr_row,
  output logic            done
);

  function automatic logic [CW-1:0] col_of(input logic [AW-1:0] a);
    int t;
    t = int'(a) / CLEN;
    return t[CW-1:0];
  endfunction

  function automatic logic [RW-1:0] row_of(input logic [AW-1:0] a);
    int t;
    t = int'(a) % CLEN;
    return t[RW-1:0];
  endfunction

  function automatic logic [CLEN-1:0] row_span(input int lo, input int hi);
    logic [CLEN-1:0] m;
    for (int r = 0; r < CLEN; r++) m[r] = (r >= lo) && (r <= hi);
    return m;
  endfunction

  function automatic logic [NCOL-1:0] col_span(input int lo, input int hi);
    logic [NCOL-1:0] m;
    for (int c = 0; c < NCOL; c++) m[c] = (c >= lo) && (c <= hi);
    return m;
  endfunction

  sms_step_e       state;
  logic [CW-1:0]   ci, cd;
  logic [RW-1:0]   ri, rd;
  logic [2:0]      step_cnt;
  int              gap;

  assign cmd_ready = (state == ST_IDLE);
  assign accept    = cmd_ready && cmd_valid;
  assign accept_up = (cmd_ins <= cmd_del);
  assign wr_row    = ri;
  assign gap       = up ? (int'(cd) - int'(ci)) : (int'(ci) - int'(cd));

  always_comb begin
    col_en = '0;
    row_en = '0;
    wr_en  = 1'b0;
    case (state)
      ST_DEL: begin
        col_en = col_span(int'(cd), int'(cd));
        row_en = up ? row_span(0, int'(rd)) : row_span(int'(rd), CLEN - 1);
      end
      ST_MID: begin
        col_en = up ? col_span(int'(ci) + 1, int'(cd) - 1)
                    : col_span(int'(cd) + 1, int'(ci) - 1);
        row_en = '1;
      end
      ST_INS: begin
        col_en = col_span(int'(ci), int'(ci));
        wr_en  = 1'b1;
        if (ci == cd)
          row_en = (ri <= rd) ? row_span(int'(ri), int'(rd)) : row_span(int'(rd), int'(ri));
        else
          row_en = up ? row_span(int'(ri), CLEN - 1) : row_span(0, int'(ri));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ci    <= '0;
      cd    <= '0;
      ri    <= '0;
      rd    <= '0;
      up    <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          ci    <= col_of(cmd_ins);
          cd    <= col_of(cmd_del);
          ri    <= row_of(cmd_ins);
          rd    <= row_of(cmd_del);
          up    <= accept_up;
          state <= (col_of(cmd_ins) == col_of(cmd_del)) ? ST_INS : ST_DEL;
        end
        ST_DEL:  state <= (gap > 1) ? ST_MID : ST_INS;
        ST_MID:  state <= ST_INS;
        default: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state == ST_IDLE) step_cnt <= '0;
    else                            step_cnt <= step_cnt + 3'd1;
  end

  assert_step_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (step_cnt < 3'd3));
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);
  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en));
  assert_single_column_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_MID) |-> $onehot0(col_en));
  assert_rows_with_cols_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|col_en) |-> (|row_en));

endmodule

// File: rtl/sms_cols.sv
module sms_cols #(
  parameter int NCOL = 4,
  parameter int CLEN = 8,
  parameter int W    = 16,
  parameter int AW   = 5,
  parameter int RW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            latch,
  input  logic            latch_up,
  input  logic [W-1:0]    latch_data,
  input  logic [NCOL-1:0] col_en,
  input  logic [CLEN-1:0] row_en,
  input  logic            up,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_row,
  input  logic [AW-1:0]   rd_addr,
  output logic [W-1:0]    rd_data
);
  localparam int N = NCOL * CLEN;

  logic [W-1:0] words   [N];
  logic [W-1:0] carry_w [NCOL];
  logic [W-1:0] wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)     wdata <= '0;
    else if (latch) wdata <= latch_data;
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [W-1:0] carry;
    always_ff @(posedge clk) begin
      if (!rst_n)     carry <= '0;
      else if (latch) carry <= latch_up ? words[c*CLEN + CLEN - 1] : words[c*CLEN];
    end
    assign carry_w[c] = carry;

    for (genvar r = 0; r < CLEN; r++) begin : g_row
      localparam int IDX = c * CLEN + r;
      logic [W-1:0] q, from_lo, from_hi;

      if (r > 0)       begin : g_lo_in assign from_lo = words[IDX-1]; end
      else if (c > 0)  begin : g_lo_cy assign from_lo = carry_w[c-1]; end
      else             begin : g_lo_z  assign from_lo = '0; end

      if (r < CLEN - 1)     begin : g_hi_in assign from_hi = words[IDX+1]; end
      else if (c < NCOL-1)  begin : g_hi_cy assign from_hi = carry_w[c+1]; end
      else                  begin : g_hi_z  assign from_hi = '0; end

      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (col_en[c] && row_en[r]) begin
          if (wr_en && wr_row == RW'(r)) q <= wdata;
          else if (up)                    q <= from_lo;
          else                            q <= from_hi;
        end
      end
      assign words[IDX] = q;
    end
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/sms_shift_top.sv
module sms_shift_top #(
  parameter int NCOL = 4,
  parameter int CLEN = 8,
  parameter int W    = 16,
  localparam int AW  = $clog2(NCOL * CLEN),
  localparam int RW  = (CLEN > 1) ? $clog2(CLEN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [AW-1:0]   cmd_ins,
  input  logic [AW-1:0]   cmd_del,
  input  logic [W-1:0]    cmd_data,
  output logic            done,
  output logic [NCOL-1:0] col_en,
  output logic [NCOL-1:0] col_dir,
  output logic [CLEN-1:0] row_en,
  output logic            wr_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [W-1:0]    rd_data
);
  logic          accept, accept_up, up;
  logic [RW-1:0] wr_row;

  sms_seq #(.NCOL(NCOL), .CLEN(CLEN), .AW(AW), .RW(RW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ins(cmd_ins),
    .cmd_del(cmd_del), .cmd_ready(cmd_ready), .accept(accept),
    .accept_up(accept_up), .up(up), .col_en(col_en), .row_en(row_en),
    .wr_en(wr_en), .wr_row(wr_row), .done(done)
  );

  sms_cols #(.NCOL(NCOL), .CLEN(CLEN), .W(W), .AW(AW), .RW(RW)) u_cols (
    .clk(clk), .rst_n(rst_n), .latch(accept), .latch_up(accept_up),
    .latch_data(cmd_data), .col_en(col_en), .row_en(row_en), .up(up),
    .wr_en(wr_en), .wr_row(wr_row), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_dir
    assign col_dir[c] = col_en[c] & (up ^ (c % 2 == 1));
  end

endmodule

// File: tb/tb_sms_shift_top.sv
module tb_sms_shift_top;
  localparam int NCOL = 4;
  localparam int CLEN = 8;
  localparam int W    = 16;
  localparam int AW   = 5;
  localparam int N    = NCOL * CLEN;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [AW-1:0]   cmd_ins = '0;
  logic [AW-1:0]   cmd_del = '0;
  logic [W-1:0]    cmd_data = '0;
  logic            done;
  logic [NCOL-1:0] col_en;
  logic [NCOL-1:0] col_dir;
  logic [CLEN-1:0] row_en;
  logic            wr_en;
  logic [AW-1:0]   rd_addr = '0;
  logic [W-1:0]    rd_data;

  int checks = 0;
  int errors = 0;
  int model [N];

  always #4 clk = ~clk;

  sms_shift_top #(.NCOL(NCOL), .CLEN(CLEN), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_ins(cmd_ins), .cmd_del(cmd_del), .cmd_data(cmd_data), .done(done),
    .col_en(col_en), .col_dir(col_dir), .row_en(row_en), .wr_en(wr_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int span(input int lo, input int hi);
    int m = 0;
    for (int i = lo; i <= hi; i++) m |= (1 << i);
    return m;
  endfunction

  function automatic int dirs(input int cols, input bit up);
    int m = 0;
    for (int c = 0; c < NCOL; c++)
      if (cols[c]) m |= ((int'(up) ^ (c % 2)) << c);
    return m;
  endfunction

  task automatic compare_all(input string req);
    for (int a = 0; a < N; a++) begin
      rd_addr = AW'(a);
      #1;
      check(int'(rd_data) == model[a], req, $sformatf("word %0d", a),
            int'(rd_data), model[a]);
    end
  endtask

  task automatic run_cmd(input int ins, input int del, input int data,
                         input bit hold, input string req);
    int ci = ins / CLEN, ri = ins % CLEN, cd = del / CLEN, rd = del % CLEN;
    bit up = (ins <= del);
    int ns = 0;
    int ecol [3];
    int erow [3];
    int ewr  [3];
    if (ci == cd) begin
      ecol[0] = 1 << ci;
      erow[0] = (ri <= rd) ? span(ri, rd) : span(rd, ri);
      ewr[0] = 1; ns = 1;
    end else begin
      ecol[0] = 1 << cd;
      erow[0] = up ? span(0, rd) : span(rd, CLEN - 1);
      ewr[0] = 0; ns = 1;
      if ((up ? cd - ci : ci - cd) > 1) begin
        ecol[ns] = up ? span(ci + 1, cd - 1) : span(cd + 1, ci - 1);
        erow[ns] = span(0, CLEN - 1);
        ewr[ns] = 0; ns++;
      end
      ecol[ns] = 1 << ci;
      erow[ns] = up ? span(ri, CLEN - 1) : span(0, ri);
      ewr[ns] = 1; ns++;
    end

    @(negedge clk);
    check(cmd_ready == 1'b1, "R9", "ready before command", int'(cmd_ready), 1);
    cmd_ins = AW'(ins); cmd_del = AW'(del); cmd_data = W'(data); cmd_valid = 1'b1;
    for (int k = 0; k < ns; k++) begin
      @(negedge clk);
      if (hold) begin
        cmd_ins = AW'(N - 1 - ins); cmd_del = AW'(ins);
        cmd_data = 16'hDEAD;
      end else cmd_valid = 1'b0;
      if (k == ns - 1) cmd_valid = 1'b0;
      check(int'(col_en) == ecol[k], (k == ns - 1) ? "R8" : (k == 0 ? "R6" : "R7"),
            $sformatf("col_en step %0d", k), int'(col_en), ecol[k]);
      check(int'(row_en) == erow[k], (k == ns - 1) ? "R8" : (k == 0 ? "R6" : "R7"),
            $sformatf("row_en step %0d", k), int'(row_en), erow[k]);
      check(int'(wr_en) == ewr[k], "R8", $sformatf("wr_en step %0d", k),
            int'(wr_en), ewr[k]);
      check(int'(col_dir) == dirs(ecol[k], up), "R10",
            $sformatf("col_dir step %0d", k), int'(col_dir), dirs(ecol[k], up));
      check(cmd_ready == 1'b0 && done == 1'b0, hold ? "R11" : "R9",
            "ready/done low while busy", int'({cmd_ready, done}), 0);
    end
    @(negedge clk);
    check(done == 1'b1 && cmd_ready == 1'b1, "R9", "done pulse after last step",
          int'({done, cmd_ready}), 3);
    check(col_en == '0 && wr_en == 1'b0, "R9", "idle enables", int'(col_en), 0);
    if (up) begin
      for (int a = del; a > ins; a--) model[a] = model[a-1];
    end else begin
      for (int a = del; a < ins; a++) model[a] = model[a+1];
    end
    model[ins] = data & 16'hFFFF;
    compare_all(req);
    @(negedge clk);
    check(done == 1'b0, "R9", "done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired: R9 run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < N; a++) model[a] = 0;
    repeat (3) @(negedge clk);
    check(cmd_ready == 1'b1 && done == 1'b0, "R1", "reset handshake",
          int'({cmd_ready, done}), 2);
    check(col_en == '0 && row_en == '0 && col_dir == '0 && wr_en == 1'b0, "R1",
          "reset enables", int'(row_en), 0);
    compare_all("R1");
    rst_n = 1'b1;

    for (int a = 0; a < N; a++) run_cmd(a, a, 100 + 7 * a, 1'b0, "R4");

    run_cmd(2, 5, 16'h1111, 1'b0, "R2");
    run_cmd(14, 9, 16'h2222, 1'b0, "R3");
    run_cmd(3, 10, 16'h3333, 1'b0, "R5");
    run_cmd(12, 4, 16'h4444, 1'b0, "R5");
    run_cmd(1, 30, 16'h5555, 1'b0, "R2");
    run_cmd(29, 2, 16'h6666, 1'b1, "R11");
    run_cmd(0, 31, 16'h7777, 1'b0, "R2");
    run_cmd(31, 0, 16'h8888, 1'b0, "R3");
    run_cmd(7, 8, 16'h9999, 1'b1, "R11");
    run_cmd(23, 17, 16'hAAAA, 1'b0, "R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule